// File: doc/BRIEF.md
# Event Counter Bank With Freeze

The block holds a bank of event counters that share one overflow status register, one global freeze flag and one overflow interrupt that can be masked. Each counter adds one on every clock edge at which its event input is high and monitoring is running. When a counter wraps from all ones back to zero, it sets a sticky status bit of its own. If that counter's interrupt enable is on, the same edge also freezes the whole bank and, unless the interrupt is masked, latches a pending interrupt request.

Software reaches all state through one register port with a write strobe and a combinational read. It can load any counter, set the per-counter interrupt enables, write the freeze flag and the sticky bits, set the mask, and acknowledge the pending request. A separate monitor-interrupt input freezes the bank without pending the overflow interrupt. Register map, with `N` the counter count (8 by default): address k for k below N is counter k; address N holds the interrupt enables (bit k for counter k); address N+1 is the status register; address N+2 is the control register; all other addresses read zero.

Top module: `event_counter_bank`

## Requirements
- R1: After reset every counter, sticky bit, interrupt enable, the mask and the pending flag are 0, the freeze flag (status bit 0) is 0, and `irq_o` is low.
- R2: While the freeze flag is 0, counter k adds one on each clock edge with `evt_i[k]` high and holds its value on edges with `evt_i[k]` low.
- R3: A counter at all ones that receives an event becomes zero and, on the same edge, sets its status bit at position 4+k. The bit stays 1 until software writes the status register, and several bits can be 1 together. It is set whatever the counter's interrupt enable is.
- R4: When a counter wraps while its interrupt-enable bit is 1, the freeze flag becomes 1 on the same edge. A wrap with the enable at 0 leaves the freeze flag unchanged.
- R5: While the freeze flag is 1, events change no counter and no status bit. Software writes still take effect.
- R6: A high `mon_irq_i` sets the freeze flag on the next edge, and it does not pend the interrupt.
- R7: A status-register write loads the freeze flag from data bit 0 and the sticky bits from data bits 4+k. Status bits 3:1 always read 0, and writes to them are ignored.
- R8: A wrap with its interrupt enable at 1 sets the pending flag when the mask (control bit 0) is 0, and leaves it unchanged when the mask is 1. `irq_o` shows the pending flag. The control register reads back mask in bit 0 and pending in bit 1.
- R9: Writing a control word with bit 1 set clears the pending flag. A new enabled wrap on the same edge keeps it set.
- R10: When a status write and a hardware set fall on the same edge, the hardware set wins for each status bit and for the freeze flag.
- R11: A write to counter address k loads the counter from the write data. An event on the same edge is dropped and does not count as a wrap.
- R12: The interrupt enables read back as written. Addresses above N+2 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_CTR | One event strobe per counter |
| mon_irq_i | input | 1 | External monitor interrupt; freezes the bank |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Combinational read data for `reg_addr_i` |
| irq_o | output | 1 | Pending overflow interrupt request |

## Verification
The hardest cases to reach are the ones where a counter wraps on the same edge as a software write that would undo its effect: a status write clearing the flag being set, or an acknowledge clearing the pending request being raised. Waiting 65536 events for a wrap is not practical, so the bench first loads a counter to all ones through the register port. It then drives the event and the conflicting write within one clock. The wrap path is swept over every counter and every combination of interrupt enable and mask. Each case ends by reading back the counter, the status register, the control register and `irq_o`.

// File: rtl/ecb_pkg.sv
package ecb_pkg;

    // Position of counter 0's sticky bit in the status register; bits
    // between the freeze flag and this position are reserved.
    localparam int STAT_BASE = 4;

    // Bit positions in the control register.
    localparam int CTRL_MASK_BIT = 0;
    localparam int CTRL_PEND_BIT = 1;

    function automatic int stat_width(input int n_ctr);
        return STAT_BASE + n_ctr;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ecb_counter.sv
module ecb_counter #(
    parameter int CTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             wr_en,
    input  logic [CTR_W-1:0] wr_data,
    output logic [CTR_W-1:0] count_o,
    output logic             wrap_o
);

    typedef struct packed {
        logic [CTR_W-1:0] cnt;
    } ctr_state_t;

    ctr_state_t s_d, s_q;
    logic       inc;

    always_comb begin
        s_d    = s_q;
        inc    = cnt_en && !wr_en;
        wrap_o = inc && (&s_q.cnt);
        if (wr_en) begin
            s_d.cnt = wr_data;
        end else if (inc) begin
            s_d.cnt = s_q.cnt + {{(CTR_W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign count_o = s_q.cnt;

endmodule

// File: rtl/ecb_status.sv
module ecb_status
    import ecb_pkg::*;
#(
    parameter int NUM_CTR = 8,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CTR-1:0] wrap_i,
    input  logic               mon_irq_i,
    input  logic               stat_we,
    input  logic               en_we,
    input  logic               ctrl_we,
    input  logic [DATA_W-1:0]  wdata,
    output logic               freeze_o,
    output logic [NUM_CTR-1:0] sticky_o,
    output logic [NUM_CTR-1:0] irq_en_o,
    output logic               mask_o,
    output logic               pend_o
);

    typedef struct packed {
        logic               freeze;
        logic [NUM_CTR-1:0] sticky;
        logic [NUM_CTR-1:0] irq_en;
        logic               mask;
        logic               pend;
    } stat_state_t;

    stat_state_t        s_d, s_q;
    logic [NUM_CTR-1:0] hw_stick;
    logic               ovf_int;
    logic               unused_wdata;

    assign unused_wdata = ^wdata;

    always_comb begin
        s_d      = s_q;
        hw_stick = s_q.freeze ? '0 : wrap_i;
        ovf_int  = |(hw_stick & s_q.irq_en);

        if (stat_we) begin
            s_d.freeze = wdata[0];
            s_d.sticky = wdata[STAT_BASE +: NUM_CTR];
        end
        s_d.sticky = s_d.sticky | hw_stick;
        if (ovf_int || mon_irq_i) begin
            s_d.freeze = 1'b1;
        end

        if (en_we) begin
            s_d.irq_en = wdata[NUM_CTR-1:0];
        end

        if (ctrl_we) begin
            s_d.mask = wdata[CTRL_MASK_BIT];
            if (wdata[CTRL_PEND_BIT]) begin
                s_d.pend = 1'b0;
            end
        end
        if (ovf_int && !s_q.mask) begin
            s_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign freeze_o = s_q.freeze;
    assign sticky_o = s_q.sticky;
    assign irq_en_o = s_q.irq_en;
    assign mask_o   = s_q.mask;
    assign pend_o   = s_q.pend;

endmodule

// File: rtl/ecb_regif.sv
module ecb_regif
    import ecb_pkg::*;
#(
    parameter int NUM_CTR = 8,
    parameter int CTR_W   = 16,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 16
) (
    input  logic                     we,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NUM_CTR*CTR_W-1:0] cnt_flat,
    input  logic [NUM_CTR-1:0]       irq_en,
    input  logic [NUM_CTR-1:0]       sticky,
    input  logic                     freeze,
    input  logic                     mask,
    input  logic                     pend,
    output logic [NUM_CTR-1:0]       cnt_we,
    output logic                     en_we,
    output logic                     stat_we,
    output logic                     ctrl_we,
    output logic [DATA_W-1:0]        rdata
);

    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(NUM_CTR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(NUM_CTR + 1);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(NUM_CTR + 2);

    always_comb begin
        cnt_we  = '0;
        rdata   = '0;
        en_we   = we && (addr == A_EN);
        stat_we = we && (addr == A_STAT);
        ctrl_we = we && (addr == A_CTRL);

        for (int k = 0; k < NUM_CTR; k++) begin
            if (addr == ADDR_W'(k)) begin
                cnt_we[k]         = we;
                rdata[CTR_W-1:0]  = cnt_flat[k*CTR_W +: CTR_W];
            end
        end

        if (addr == A_EN) begin
            rdata[NUM_CTR-1:0] = irq_en;
        end
        if (addr == A_STAT) begin
            rdata[0]                    = freeze;
            rdata[STAT_BASE +: NUM_CTR] = sticky;
        end
        if (addr == A_CTRL) begin
            rdata[CTRL_MASK_BIT] = mask;
            rdata[CTRL_PEND_BIT] = pend;
        end
    end

endmodule

// File: rtl/event_counter_bank.sv
module event_counter_bank
    import ecb_pkg::*;
#(
    parameter  int NUM_CTR = 8,
    parameter  int CTR_W   = 16,
    localparam int STAT_W  = stat_width(NUM_CTR),
    localparam int DATA_W  = max_int(CTR_W, STAT_W),
    localparam int ADDR_W  = $clog2(NUM_CTR + 3)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CTR-1:0] evt_i,
    input  logic               mon_irq_i,
    input  logic               reg_we_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic               irq_o
);

    logic [NUM_CTR*CTR_W-1:0] cnt_flat;
    logic [NUM_CTR-1:0]       wrap_vec;
    logic [NUM_CTR-1:0]       cnt_we;
    logic [NUM_CTR-1:0]       sticky;
    logic [NUM_CTR-1:0]       irq_en;
    logic                     freeze_q;
    logic                     mask_q;
    logic                     pend_q;
    logic                     en_we;
    logic                     stat_we;
    logic                     ctrl_we;

    for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
        ecb_counter #(
            .CTR_W (CTR_W)
        ) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .cnt_en  (evt_i[k] && !freeze_q),
            .wr_en   (cnt_we[k]),
            .wr_data (reg_wdata_i[CTR_W-1:0]),
            .count_o (cnt_flat[k*CTR_W +: CTR_W]),
            .wrap_o  (wrap_vec[k])
        );
    end

    ecb_status #(
        .NUM_CTR (NUM_CTR),
        .DATA_W  (DATA_W)
    ) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .wrap_i    (wrap_vec),
        .mon_irq_i (mon_irq_i),
        .stat_we   (stat_we),
        .en_we     (en_we),
        .ctrl_we   (ctrl_we),
        .wdata     (reg_wdata_i),
        .freeze_o  (freeze_q),
        .sticky_o  (sticky),
        .irq_en_o  (irq_en),
        .mask_o    (mask_q),
        .pend_o    (pend_q)
    );

    ecb_regif #(
        .NUM_CTR (NUM_CTR),
        .CTR_W   (CTR_W),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W)
    ) u_regif (
        .we       (reg_we_i),
        .addr     (reg_addr_i),
        .cnt_flat (cnt_flat),
        .irq_en   (irq_en),
        .sticky   (sticky),
        .freeze   (freeze_q),
        .mask     (mask_q),
        .pend     (pend_q),
        .cnt_we   (cnt_we),
        .en_we    (en_we),
        .stat_we  (stat_we),
        .ctrl_we  (ctrl_we),
        .rdata    (reg_rdata_o)
    );

    assign irq_o = pend_q;

endmodule

// File: rtl/ecb_chk.sv
module ecb_chk #(
    parameter int NUM_CTR = 8,
    parameter int CTR_W   = 16,
    parameter int ADDR_W  = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     mon_irq_i,
    input logic                     reg_we_i,
    input logic [ADDR_W-1:0]        reg_addr_i,
    input logic                     irq_o,
    input logic [NUM_CTR*CTR_W-1:0] cnt_flat,
    input logic [NUM_CTR-1:0]       wrap_vec,
    input logic [NUM_CTR-1:0]       sticky,
    input logic [NUM_CTR-1:0]       irq_en,
    input logic                     freeze_q,
    input logic                     mask_q
);

    logic stat_wr;
    logic ctrl_wr;

    assign stat_wr = reg_we_i && (reg_addr_i == ADDR_W'(NUM_CTR + 1));
    assign ctrl_wr = reg_we_i && (reg_addr_i == ADDR_W'(NUM_CTR + 2));

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> ((sticky & $past(sticky)) == $past(sticky)));

    // R4
    ovf_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(wrap_vec & irq_en)) |=> freeze_q);

    // R5
    frozen_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_q && !stat_wr) |=> $stable(sticky));

    // R5
    frozen_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_q && !reg_we_i) |=> $stable(cnt_flat));

    // R6
    mon_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mon_irq_i |=> freeze_q);

    // R8
    mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q && !irq_o && !ctrl_wr) |=> !irq_o);

    // R9
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ctrl_wr) |=> irq_o);

endmodule

bind event_counter_bank ecb_chk #(
    .NUM_CTR (NUM_CTR),
    .CTR_W   (CTR_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mon_irq_i  (mon_irq_i),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .irq_o      (irq_o),
    .cnt_flat   (cnt_flat),
    .wrap_vec   (wrap_vec),
    .sticky     (sticky),
    .irq_en     (irq_en),
    .freeze_q   (freeze_q),
    .mask_q     (mask_q)
);

// File: tb/event_counter_bank_tb.sv
module event_counter_bank_tb;

    localparam int N    = 8;
    localparam int A_EN = 8;
    localparam int A_ST = 9;
    localparam int A_CT = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  evt_i = '0;
    logic        mon_irq_i = 1'b0;
    logic        reg_we_i = 1'b0;
    logic [3:0]  reg_addr_i = '0;
    logic [15:0] reg_wdata_i = '0;
    logic [15:0] reg_rdata_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    event_counter_bank u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt_i),
        .mon_irq_i   (mon_irq_i),
        .reg_we_i    (reg_we_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .irq_o       (irq_o)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // One clock with the given inputs; returns at the following falling edge.
    task automatic cyc(input logic [7:0] ev, input logic we, input int a,
                       input logic [15:0] d, input logic mon);
        @(negedge clk);
        evt_i       = ev;
        reg_we_i    = we;
        reg_addr_i  = 4'(a);
        reg_wdata_i = d;
        mon_irq_i   = mon;
        @(negedge clk);
        evt_i     = '0;
        reg_we_i  = 1'b0;
        mon_irq_i = 1'b0;
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        cyc(8'h00, 1'b1, a, d, 1'b0);
    endtask

    task automatic rd(input int a, output logic [15:0] d);
        reg_addr_i = 4'(a);
        #1;
        d = reg_rdata_o;
    endtask

    task automatic rdchk(input string req, input int a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        chk(req, {16'h0, v}, {16'h0, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int exp_cnt [N];
        logic [15:0] exp_st;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: every register reads zero after reset
        for (int a = 0; a < 11; a++) rdchk("R1 reset value", a, 16'h0);
        chk("R1 irq after reset", {31'h0, irq_o}, 32'h0);

        // R12: enable readback and unmapped addresses
        wr(A_EN, 16'h00A5);
        rdchk("R12 enable readback", A_EN, 16'h00A5);
        for (int a = 11; a < 16; a++) rdchk("R12 unmapped read", a, 16'h0);
        wr(A_EN, 16'h0000);

        // R11: counter load and readback
        for (int k = 0; k < N; k++) wr(k, 16'(k * 16'h1111 + 3));
        for (int k = 0; k < N; k++) rdchk("R11 counter load", k, 16'(k * 16'h1111 + 3));

        // R2: sweep of event patterns with an arithmetic model
        for (int k = 0; k < N; k++) begin
            wr(k, 16'h0);
            exp_cnt[k] = 0;
        end
        for (int i = 0; i < 48; i++) begin
            logic [7:0] p;
            p = 8'((i * 37 + 11) & 8'hFF);
            cyc(p, 1'b0, 0, 16'h0, 1'b0);
            for (int k = 0; k < N; k++) if (p[k]) exp_cnt[k]++;
        end
        for (int k = 0; k < N; k++) rdchk("R2 event count", k, 16'(exp_cnt[k]));

        // R11: a write wins over an event on the same edge
        cyc(8'h04, 1'b1, 2, 16'h1234, 1'b0);
        rdchk("R11 write beats event", 2, 16'h1234);
        rdchk("R11 no status from write", A_ST, 16'h0);

        // R3 R4 R8: wrap sweep over every counter, enable and mask
        for (int k = 0; k < N; k++) begin
            for (int en = 0; en < 2; en++) begin
                for (int m = 0; m < 2; m++) begin
                    wr(A_ST, 16'h0);
                    wr(A_CT, 16'(2 | m));
                    wr(A_EN, en ? 16'(1 << k) : 16'h0);
                    wr(k, 16'hFFFF);
                    cyc(8'(1 << k), 1'b0, 0, 16'h0, 1'b0);
                    rdchk("R3 wrap to zero", k, 16'h0);
                    exp_st = 16'(1 << (4 + k)) | (en ? 16'h1 : 16'h0);
                    rdchk("R3 R4 status after wrap", A_ST, exp_st);
                    chk("R8 irq after wrap", {31'h0, irq_o}, {31'h0, (en == 1 && m == 0)});
                    rdchk("R8 control readback", A_CT,
                          16'(m | ((en == 1 && m == 0) ? 2 : 0)));
                    cyc(8'(1 << k), 1'b0, 0, 16'h0, 1'b0);
                    rdchk("R4 R5 count after wrap", k, (en == 1) ? 16'h0 : 16'h1);
                end
            end
        end
        wr(A_CT, 16'h0002);
        wr(A_EN, 16'h0000);

        // R3: two counters wrap together; bits are sticky
        wr(A_ST, 16'h0);
        wr(1, 16'hFFFF);
        wr(5, 16'hFFFF);
        cyc(8'h22, 1'b0, 0, 16'h0, 1'b0);
        rdchk("R3 multiple bits", A_ST, 16'h0220);
        cyc(8'hFF, 1'b0, 0, 16'h0, 1'b0);
        cyc(8'h01, 1'b0, 0, 16'h0, 1'b0);
        rdchk("R3 sticky hold", A_ST, 16'h0220);

        // R7: reserved bits ignored; freeze written by software
        wr(A_ST, 16'h000E);
        rdchk("R7 reserved bits", A_ST, 16'h0);
        wr(A_ST, 16'h0001);
        rdchk("R7 freeze set", A_ST, 16'h0001);
        chk("R7 freeze pends nothing", {31'h0, irq_o}, 32'h0);

        // R5: frozen bank ignores events; writes still work
        for (int k = 0; k < N; k++) wr(k, 16'(k * 100));
        for (int i = 0; i < 5; i++) cyc(8'hFF, 1'b0, 0, 16'h0, 1'b0);
        for (int k = 0; k < N; k++) rdchk("R5 frozen counter", k, 16'(k * 100));
        wr(6, 16'hFFFF);
        cyc(8'h40, 1'b0, 0, 16'h0, 1'b0);
        rdchk("R5 frozen no wrap", 6, 16'hFFFF);
        rdchk("R5 frozen status", A_ST, 16'h0001);
        wr(A_ST, 16'h0000);
        cyc(8'hFF, 1'b0, 0, 16'h0, 1'b0);
        for (int k = 0; k < N; k++)
            rdchk("R7 resume counting", k, (k == 6) ? 16'h0 : 16'(k * 100 + 1));
        rdchk("R7 R3 status after resume", A_ST, 16'h0400);

        // R6: monitor interrupt freezes without pending
        wr(A_ST, 16'h0);
        cyc(8'h00, 1'b0, 0, 16'h0, 1'b1);
        rdchk("R6 monitor freeze", A_ST, 16'h0001);
        chk("R6 no pend", {31'h0, irq_o}, 32'h0);
        cyc(8'h01, 1'b0, 0, 16'h0, 1'b0);
        rdchk("R6 frozen count", 0, 16'h0001);

        // R10: hardware set beats a same-edge status write
        wr(A_ST, 16'h0);
        wr(A_EN, 16'h0008);
        wr(3, 16'hFFFF);
        cyc(8'h08, 1'b1, A_ST, 16'h0000, 1'b0);
        rdchk("R10 hw beats sw", A_ST, 16'h0081);
        chk("R10 irq", {31'h0, irq_o}, 32'h1);

        // R9: set beats acknowledge; acknowledge alone clears
        wr(A_ST, 16'h0);
        wr(A_EN, 16'h0001);
        wr(0, 16'hFFFF);
        cyc(8'h01, 1'b1, A_CT, 16'h0002, 1'b0);
        chk("R9 set beats ack", {31'h0, irq_o}, 32'h1);
        rdchk("R9 control pending", A_CT, 16'h0002);
        wr(A_CT, 16'h0002);
        chk("R9 ack clears", {31'h0, irq_o}, 32'h0);
        rdchk("R9 control after ack", A_CT, 16'h0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule